// File: doc/BRIEF.md
# Reset and power-good supervisor

This block watches the in-regulation indications of five supply channels (A to E) and turns them into two digital flags: a reset flag tied to the core channel A, and a power-good flag tied to a selectable group of channels. A control byte sets three things for each flag: the polarity of its output pin, the delay before it releases, and, for the power-good flag, which channels it monitors. The analog threshold comparators sit outside the block. Each channel arrives here as a single good bit.

A flag enters its fail state on the clock after its monitored condition goes bad. It leaves that state only after the condition has stayed good for a delay counted in ticks of a millisecond strobe. If the condition fails while the delay is running, the count starts again from zero. The output drivers are supplied by channel B. When that channel is off, both outputs are held low whatever their state.

Top module: `rail_supervisor`

## Requirements
- R1: After `rst_ni` is released, both flags start in their fail state. Control code 01 in bits 1:0 of `ctrl_i` gives the reset flag a release delay of 100 ms, so with good inputs and a tick every cycle it releases on the 101st clock edge.
- R2: A low `good_i[0]` (channel A) puts the reset flag into its fail state on the next clock edge.
- R3: The delay codes map as 00→3·STEP_TICKS, 01→2·STEP_TICKS, 10→STEP_TICKS and 11→0 ticks, with STEP_TICKS = 50 ticks (50 ms) by default. After the monitored condition turns good, each tick advances the count by one. The flag releases on the first clock edge at which the count has reached the limit.
- R4: A failure of the monitored condition during the delay clears the count, and the full delay is counted again once the condition is good.
- R5: With `ctrl_i[6]` = 0, `rst_flag_o` is high in the fail state and low when released. With `ctrl_i[6]` = 1, both levels are inverted.
- R6: With `ctrl_i[7]` = 0, `pg_flag_o` is high in the fail state and low when released. With `ctrl_i[7]` = 1, both levels are inverted.
- R7: `ctrl_i[5:4]` selects the power-good group: 00 = A, C, D and E must all be good; 01 = E only; 10 = C only; 11 = D only. Channels outside the group have no effect.
- R8: `ctrl_i[3:2]` selects the power-good release delay, using the code mapping of R3.
- R9: While `drv_en_i` (channel B on) is low, both outputs are driven low. The internal flag state keeps evolving, and it reappears at the outputs when `drv_en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle strobe, once per millisecond |
| ctrl_i | input | 8 | Control byte: [1:0] reset delay, [3:2] power-good delay, [5:4] group, [6] reset polarity, [7] power-good polarity |
| good_i | input | 5 | In-regulation bits, [0]=A, [1]=B, [2]=C, [3]=D, [4]=E |
| drv_en_i | input | 1 | Output-driver supply channel enabled |
| rst_flag_o | output | 1 | Reset flag, polarity per ctrl_i[6] |
| pg_flag_o | output | 1 | Power-good flag, polarity per ctrl_i[7] |

## Verification
The tightest collision is a failure of the monitored condition in the same cycle in which the delay count reaches its limit, or in which a tick arrives. In that cycle the restart must win over both the release and the increment. The random phase provokes this by flipping good bits often, with a tick roughly every other cycle and delay codes that include zero. A cycle model in the bench judges every cycle against the requirement rules. Polarity, group or delay-code changes that land mid-count are also exercised, because the control byte is re-drawn at random while both timers are running.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned NUM_CH = 5;
  localparam int unsigned CH_A = 0;
  localparam int unsigned CH_C = 2;
  localparam int unsigned CH_D = 3;
  localparam int unsigned CH_E = 4;

  typedef enum logic [1:0] {
    GRP_ALL = 2'b00,
    GRP_E   = 2'b01,
    GRP_C   = 2'b10,
    GRP_D   = 2'b11
  } grp_sel_e;

  typedef struct packed {
    logic     pg_pol;
    logic     rst_pol;
    grp_sel_e grp;
    logic [1:0] pg_dly;
    logic [1:0] rst_dly;
  } ctrl_t;

  // code 00 is the longest delay, 11 is none
  function automatic int unsigned dly_steps(logic [1:0] code);
    return 32'd3 - {30'd0, code};
  endfunction
endpackage

// File: rtl/rs_group_mux.sv
module rs_group_mux
  import rs_pkg::*;
(
  input  logic [NUM_CH-1:0] good_i,
  input  grp_sel_e          sel_i,
  output logic              grp_good_o
);
  always_comb begin
    unique case (sel_i)
      GRP_ALL: grp_good_o = good_i[CH_A] & good_i[CH_C] & good_i[CH_D] & good_i[CH_E];
      GRP_E:   grp_good_o = good_i[CH_E];
      GRP_C:   grp_good_o = good_i[CH_C];
      GRP_D:   grp_good_o = good_i[CH_D];
      default: grp_good_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rs_release_timer.sv
module rs_release_timer
  import rs_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STEP_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fail_i,
  input  logic [1:0] code_i,
  output logic       active_o
);
  localparam int unsigned MAX_TICKS = 3 * STEP_TICKS;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             active_q;

  assign limit = CNT_W'(dly_steps(code_i) * STEP_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (fail_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q >= limit) active_q <= 1'b0;
      else if (tick_i)    cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;

  initial begin
    assert_limit_fits_R3: assert (MAX_TICKS < (2 ** CNT_W))
      else $error("delay range exceeds counter width");
  end

  assert_fail_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> active_q);

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> (cnt_q == '0));

  assert_release_at_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(cnt_q) >= $past(limit)));

  assert_count_only_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rs_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STEP_TICKS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_ms_i,
  input  logic [7:0]        ctrl_i,
  input  logic [NUM_CH-1:0] good_i,
  input  logic              drv_en_i,
  output logic              rst_flag_o,
  output logic              pg_flag_o
);
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned F_RST = 0;
  localparam int unsigned F_PG  = 1;

  ctrl_t ctrl;
  logic  grp_good;
  logic [NUM_FLAGS-1:0] fail;
  logic [NUM_FLAGS-1:0] active;
  logic [NUM_FLAGS-1:0] pol;
  logic [1:0]           code [NUM_FLAGS];
  logic [NUM_FLAGS-1:0] pin;

  assign ctrl = ctrl_t'(ctrl_i);

  rs_group_mux i_group_mux (
    .good_i     (good_i),
    .sel_i      (ctrl.grp),
    .grp_good_o (grp_good)
  );

  assign fail[F_RST] = ~good_i[CH_A];
  assign fail[F_PG]  = ~grp_good;
  assign code[F_RST] = ctrl.rst_dly;
  assign code[F_PG]  = ctrl.pg_dly;
  assign pol[F_RST]  = ctrl.rst_pol;
  assign pol[F_PG]   = ctrl.pg_pol;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    rs_release_timer #(
      .CNT_W      (CNT_W),
      .STEP_TICKS (STEP_TICKS)
    ) i_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_ms_i),
      .fail_i   (fail[f]),
      .code_i   (code[f]),
      .active_o (active[f])
    );
    // pol 0: high while failing; drivers unpowered when channel B off
    assign pin[f] = drv_en_i & (active[f] ^ pol[f]);
  end

  assign rst_flag_o = pin[F_RST];
  assign pg_flag_o  = pin[F_PG];

  assert_rst_release_needs_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active[F_RST]) |-> $past(good_i[CH_A]));

  assert_pg_release_needs_group_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active[F_PG]) |-> $past(grp_good));

  assert_unpowered_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_i |-> (!rst_flag_o && !pg_flag_o));
endmodule

// File: tb/test_rail_supervisor.sv
`timescale 1ns/1ps
module test_rail_supervisor;
  localparam int unsigned STEP = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] ctrl = 8'h05;
  logic [4:0] good = 5'h00;
  logic       drv = 1'b1;
  logic       rst_o, pg_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rail_supervisor #(.CNT_W(8), .STEP_TICKS(STEP)) i_rail_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .ctrl_i(ctrl),
    .good_i(good), .drv_en_i(drv), .rst_flag_o(rst_o), .pg_flag_o(pg_o)
  );

  function automatic int lim(logic [1:0] c);
    case (c)
      2'b00: return 3 * STEP;
      2'b01: return 2 * STEP;
      2'b10: return STEP;
      default: return 0;
    endcase
  endfunction

  function automatic logic grp_ok(logic [4:0] g, logic [1:0] s);
    case (s)
      2'b00: return g[0] & g[2] & g[3] & g[4];
      2'b01: return g[4];
      2'b10: return g[2];
      default: return g[3];
    endcase
  endfunction

  // bench cycle model built from R2-R4, R7, R8
  logic m_ract, m_pact;
  int   m_rcnt, m_pcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ract <= 1'b1; m_rcnt <= 0; m_pact <= 1'b1; m_pcnt <= 0;
    end else begin
      if (!good[0]) begin m_ract <= 1'b1; m_rcnt <= 0; end
      else if (m_ract) begin
        if (m_rcnt >= lim(ctrl[1:0])) m_ract <= 1'b0;
        else if (tick) m_rcnt <= m_rcnt + 1;
      end
      if (!grp_ok(good, ctrl[5:4])) begin m_pact <= 1'b1; m_pcnt <= 0; end
      else if (m_pact) begin
        if (m_pcnt >= lim(ctrl[3:2])) m_pact <= 1'b0;
        else if (tick) m_pcnt <= m_pcnt + 1;
      end
    end
  end

  function automatic logic pin_exp(logic act, logic pol, logic en);
    return en & (pol ? ~act : act);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick = 1'b1;
    good = 5'h1F;
    ctrl = 8'h05;   // both delays 01, group ALL, polarities 0
    @(negedge clk);
    chk("R1 reset state rst", rst_o, 1'b1);
    chk("R1 reset state pg", pg_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    edges(100);
    chk("R1 default delay not yet released", rst_o, 1'b1);
    edges(1);
    chk("R1 default delay released", rst_o, 1'b0);
    chk("R8 pg 100 ms released", pg_o, 1'b0);

    good[0] = 1'b0;
    edges(1);
    chk("R2 reset asserts next edge", rst_o, 1'b1);
    chk("R7 group ALL sees A", pg_o, 1'b1);

    // restart mid-delay
    good = 5'h1F;
    edges(30);
    good[0] = 1'b0;
    edges(1);
    good[0] = 1'b1;
    edges(100);
    chk("R4 restart still asserted", rst_o, 1'b1);
    edges(1);
    chk("R4 restart released after full delay", rst_o, 1'b0);

    // delay codes with tick every cycle
    ctrl[1:0] = 2'b10;
    good[0] = 1'b0; edges(1); good[0] = 1'b1;
    edges(50);
    chk("R3 code 10 before limit", rst_o, 1'b1);
    edges(1);
    chk("R3 code 10 release", rst_o, 1'b0);
    ctrl[1:0] = 2'b00;
    good[0] = 1'b0; edges(1); good[0] = 1'b1;
    edges(150);
    chk("R3 code 00 before limit", rst_o, 1'b1);
    edges(1);
    chk("R3 code 00 release", rst_o, 1'b0);
    ctrl[1:0] = 2'b11;
    good[0] = 1'b0; edges(1); good[0] = 1'b1;
    edges(1);
    chk("R3 code 11 release on next edge", rst_o, 1'b0);

    // ticks gate the count
    tick = 1'b0;
    ctrl[1:0] = 2'b10;
    good[0] = 1'b0; edges(1); good[0] = 1'b1;
    edges(200);
    chk("R3 no ticks no release", rst_o, 1'b1);
    tick = 1'b1;
    edges(51);
    chk("R3 release after ticks resume", rst_o, 1'b0);

    // polarity
    ctrl[6] = 1'b1;
    edges(1);
    chk("R5 inverted released", rst_o, 1'b1);
    good[0] = 1'b0; edges(1);
    chk("R5 inverted asserted", rst_o, 1'b0);
    good[0] = 1'b1;
    ctrl[7] = 1'b1;
    ctrl[3:2] = 2'b11;
    edges(2);
    chk("R6 inverted pg good", pg_o, 1'b1);
    ctrl[7] = 1'b0;
    edges(1);
    chk("R6 normal pg good", pg_o, 1'b0);

    // group select
    ctrl[5:4] = 2'b01;
    good[2] = 1'b0; good[0] = 1'b0; edges(2);
    chk("R7 group E ignores A and C", pg_o, 1'b0);
    good[4] = 1'b0; edges(1);
    chk("R7 group E fails on E", pg_o, 1'b1);
    ctrl[5:4] = 2'b11; edges(2);
    chk("R7 group D ignores E", pg_o, 1'b0);
    good[3] = 1'b0; edges(1);
    chk("R7 group D fails on D", pg_o, 1'b1);
    ctrl[5:4] = 2'b10; good[2] = 1'b1; edges(2);
    chk("R8 group C code 11 release", pg_o, 1'b0);

    // driver supply off
    ctrl[6] = 1'b0;
    drv = 1'b0; edges(1);
    chk("R9 rst low when unpowered", rst_o, 1'b0);
    chk("R9 pg low when unpowered", pg_o, 1'b0);
    drv = 1'b1; edges(1);
    chk("R9 state returns", rst_o, 1'b1);

    // random phase against the cycle model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 24) == 0) good = 5'($urandom);
      else if ($urandom_range(0, 6) == 0) good = 5'h1F;
      if ($urandom_range(0, 299) == 0) ctrl = 8'($urandom);
      if ($urandom_range(0, 149) == 0) drv = ~drv;
      tick = ($urandom_range(0, 1) == 0);
      edges(1);
      chk("R3 random rst vs model", rst_o, pin_exp(m_ract, ctrl[6], drv));
      chk("R8 random pg vs model", pg_o, pin_exp(m_pact, ctrl[7], drv));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule